// File: doc/BRIEF.md
# Converter Channel Pair Allocator

This block hands out three conversion contexts (A, B and C) to requesters and accounts for a shared pool of audio channels that all three draw on. A requester asks for a context by strobing a request with the number of channels it needs. One clock later the block reports one of three outcomes: a grant with the chosen context index, a busy error, or a capacity error. A release strobe names a context index. The context's channels go back to the pool, the context becomes free, and its run bit and sticky error flags are cleared.

The search does not go by lowest index. A is tried first, then C, and B last. B is handed out only when A and C are both taken. Each grant is also checked against the remaining channel budget. Once a context is granted, its owner can set a run bit for it. Error flags reported against it collect until it is released. The outputs show occupancy, the per-context channel counts and the free pool level, so a system controller can see the full allocation state directly.

Top module: `chan_pair_alloc`

## Requirements
- R1: After reset the pool holds 10 channels, every context is free with a recorded count of zero, all run and error bits are clear, and no response flag is raised.
- R2: Free contexts are tried in the order A (index 0), C (index 2), B (index 1). B is granted only when A and C are both occupied.
- R3: A request made while all three contexts are occupied raises the busy error. This happens even when the count would also fail the capacity or range check.
- R4: If a free context exists but the pool holds fewer channels than requested, the capacity error is raised and the pool, occupancy and counts stay unchanged.
- R5: A grant raises rsp_grant with rsp_index (A=0, B=1, C=2) in the cycle after the request. It takes the requested count from the pool, records that count in the context's 4-bit field of ctx_count (context i at bits 4i+3..4i), and marks the context occupied.
- R6: Releasing an occupied context adds its recorded count back to the pool, sets its count to zero, marks it free and clears its sticky error flag.
- R7: A requested count of 0, or any count above 10, is rejected with the capacity error and changes nothing.
- R8: A release clears the context's run bit. run_start sets the run bit only for a context that was occupied before that cycle. run_stop clears it.
- R9: If a release and a request arrive in the same cycle, the release is applied first. The request sees the freed context and the returned channels.
- R10: Releasing a context that is already free, or releasing index 3, has no effect on the pool, occupancy, counts, run or error bits.
- R11: err_set sets a context's sticky error flag only while that context is occupied. The flag stays set until the context is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_count | input | 4 | Requested channel count |
| rel_valid | input | 1 | Release strobe |
| rel_index | input | 2 | Context to release (0=A, 1=B, 2=C) |
| run_start | input | 3 | Per-context run set, one bit per context |
| run_stop | input | 3 | Per-context run clear |
| err_set | input | 3 | Per-context sticky error report |
| rsp_grant | output | 1 | Grant response, one cycle after the request |
| rsp_busy | output | 1 | Busy error response |
| rsp_cap_err | output | 1 | Capacity or range error response |
| rsp_index | output | 2 | Granted context index |
| ctx_busy | output | 3 | Occupancy per context |
| ctx_run | output | 3 | Run bit per context |
| ctx_err | output | 3 | Sticky error flag per context |
| ctx_count | output | 12 | Recorded channel counts, 4 bits per context |
| pool_avail | output | 4 | Free channels in the pool |

## Verification
Every count from 0 to 15 is requested from a fresh state. This separates the valid range from the out-of-range counts on both sides. All 100 pairs of first and second counts in the range 1 to 10 are then tried. This separates a second grant (which must land on C) from a capacity error exactly at the budget edge. Directed sequences fill all three contexts to expose the A, C, B order and busy priority. They also pair a release with a request in the same cycle to show that the release goes first, and they release free or nonexistent indices to show nothing changes. Run and error reports are sent to both free and occupied contexts to separate gated from ungated updates.

// File: rtl/chan_pair_alloc.sv
module chan_pair_alloc #(
  parameter int POOL_CHANNELS = 10,
  parameter int MAX_REQ       = 10,
  parameter int REQ_W         = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [REQ_W-1:0]     req_count,
  input  logic                 rel_valid,
  input  logic [1:0]           rel_index,
  input  logic [2:0]           run_start,
  input  logic [2:0]           run_stop,
  input  logic [2:0]           err_set,
  output logic                 rsp_grant,
  output logic                 rsp_busy,
  output logic                 rsp_cap_err,
  output logic [1:0]           rsp_index,
  output logic [2:0]           ctx_busy,
  output logic [2:0]           ctx_run,
  output logic [2:0]           ctx_err,
  output logic [3*$clog2(POOL_CHANNELS+1)-1:0] ctx_count,
  output logic [$clog2(POOL_CHANNELS+1)-1:0]   pool_avail
);
  localparam int CW   = $clog2(POOL_CHANNELS + 1);
  localparam int NCTX = 3;

  logic [2:0]    busy_q, run_q, err_q;
  logic [CW-1:0] cnt_q [NCTX];
  logic [CW-1:0] pool_q;

  logic          rel_hit;
  logic [2:0]    rel_mask;
  logic [CW-1:0] rel_cnt;
  logic [2:0]    busy_mid;
  logic [CW-1:0] pool_mid;
  logic [2:0]    pick_mask;
  logic [1:0]    pick_idx;
  logic          none_free, count_ok, fits;
  logic          do_grant, do_busy, do_cap;
  logic [2:0]    grant_mask;

  always_comb begin
    rel_hit = 1'b0;
    rel_cnt = '0;
    case (rel_index)
      2'd0: begin rel_hit = rel_valid && busy_q[0]; rel_cnt = cnt_q[0]; end
      2'd1: begin rel_hit = rel_valid && busy_q[1]; rel_cnt = cnt_q[1]; end
      2'd2: begin rel_hit = rel_valid && busy_q[2]; rel_cnt = cnt_q[2]; end
      default: begin rel_hit = 1'b0; rel_cnt = '0; end
    endcase
    if (!rel_hit) rel_cnt = '0;
  end

  assign rel_mask = rel_hit ? (3'b001 << rel_index) : 3'b000;
  assign busy_mid = busy_q & ~rel_mask;
  assign pool_mid = pool_q + rel_cnt;

  always_comb begin
    pick_mask = 3'b000;
    pick_idx  = 2'd0;
    none_free = 1'b0;
    if (!busy_mid[0]) begin
      pick_mask = 3'b001; pick_idx = 2'd0;
    end else if (!busy_mid[2]) begin
      pick_mask = 3'b100; pick_idx = 2'd2;
    end else if (!busy_mid[1]) begin
      pick_mask = 3'b010; pick_idx = 2'd1;
    end else begin
      none_free = 1'b1;
    end
  end

  assign count_ok   = (req_count != '0) && (32'(req_count) <= MAX_REQ);
  assign fits       = 32'(req_count) <= 32'(pool_mid);
  assign do_busy    = req_valid && none_free;
  assign do_cap     = req_valid && !none_free && !(count_ok && fits);
  assign do_grant   = req_valid && !none_free && count_ok && fits;
  assign grant_mask = do_grant ? pick_mask : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= '0;
      run_q       <= '0;
      err_q       <= '0;
      pool_q      <= CW'(POOL_CHANNELS);
      rsp_grant   <= 1'b0;
      rsp_busy    <= 1'b0;
      rsp_cap_err <= 1'b0;
      rsp_index   <= 2'd0;
    end else begin
      busy_q      <= busy_mid | grant_mask;
      run_q       <= (run_q | (run_start & busy_q)) & ~run_stop & ~rel_mask;
      err_q       <= (err_q | (err_set & busy_q)) & ~rel_mask;
      pool_q      <= pool_mid - (do_grant ? CW'(req_count) : CW'(0));
      rsp_grant   <= do_grant;
      rsp_busy    <= do_busy;
      rsp_cap_err <= do_cap;
      rsp_index   <= do_grant ? pick_idx : 2'd0;
    end
  end

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q[i] <= '0;
      else if (grant_mask[i])  cnt_q[i] <= CW'(req_count);
      else if (rel_mask[i])    cnt_q[i] <= '0;
    end
    assign ctx_count[i*CW +: CW] = cnt_q[i];
  end

  assign ctx_busy   = busy_q;
  assign ctx_run    = run_q;
  assign ctx_err    = err_q;
  assign pool_avail = pool_q;
endmodule

// File: rtl/chan_pair_alloc_chk.sv
module chan_pair_alloc_chk #(
  parameter int POOL_CHANNELS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic rsp_grant,
  input logic rsp_busy,
  input logic rsp_cap_err,
  input logic [1:0] rsp_index,
  input logic [2:0] ctx_busy,
  input logic [2:0] ctx_run,
  input logic [2:0] ctx_err,
  input logic [3*$clog2(POOL_CHANNELS+1)-1:0] ctx_count,
  input logic [$clog2(POOL_CHANNELS+1)-1:0]   pool_avail
);
  localparam int CW = $clog2(POOL_CHANNELS + 1);

  p_pool_conserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pool_avail) + 32'(ctx_count[0 +: CW]) + 32'(ctx_count[CW +: CW])
      + 32'(ctx_count[2*CW +: CW]) == POOL_CHANNELS);

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_grant, rsp_busy, rsp_cap_err}));

  p_grant_occupies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> ctx_busy[rsp_index]);

  p_b_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_grant && rsp_index == 2'd1) |-> ($past(ctx_busy[0]) && $past(ctx_busy[2])));

  p_busy_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_busy |-> ($past(ctx_busy) == 3'b111));

  p_run_needs_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_run & ~ctx_busy) == 3'b000);

  p_err_needs_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_err & ~ctx_busy) == 3'b000);
endmodule

bind chan_pair_alloc chan_pair_alloc_chk #(.POOL_CHANNELS(POOL_CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_grant(rsp_grant), .rsp_busy(rsp_busy),
  .rsp_cap_err(rsp_cap_err), .rsp_index(rsp_index), .ctx_busy(ctx_busy),
  .ctx_run(ctx_run), .ctx_err(ctx_err), .ctx_count(ctx_count),
  .pool_avail(pool_avail)
);

// File: tb/test_chan_pair_alloc.sv
module test_chan_pair_alloc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_count = '0;
  logic rel_valid = 1'b0;
  logic [1:0] rel_index = '0;
  logic [2:0] run_start = '0, run_stop = '0, err_set = '0;
  logic rsp_grant, rsp_busy, rsp_cap_err;
  logic [1:0] rsp_index;
  logic [2:0] ctx_busy, ctx_run, ctx_err;
  logic [11:0] ctx_count;
  logic [3:0] pool_avail;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [2:0] m_busy, m_run, m_err;
  int m_cnt [3];
  int m_pool;
  bit e_grant, e_busy, e_cap;
  int e_idx;

  always #4 clk = ~clk;

  chan_pair_alloc i_chan_pair_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
    .rel_valid(rel_valid), .rel_index(rel_index), .run_start(run_start),
    .run_stop(run_stop), .err_set(err_set), .rsp_grant(rsp_grant),
    .rsp_busy(rsp_busy), .rsp_cap_err(rsp_cap_err), .rsp_index(rsp_index),
    .ctx_busy(ctx_busy), .ctx_run(ctx_run), .ctx_err(ctx_err),
    .ctx_count(ctx_count), .pool_avail(pool_avail)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "pool", int'(pool_avail), m_pool);
    chk(tag, "busy", int'(ctx_busy), int'(m_busy));
    chk(tag, "run", int'(ctx_run), int'(m_run));
    chk(tag, "err", int'(ctx_err), int'(m_err));
    for (int i = 0; i < 3; i++) chk(tag, "count", int'(ctx_count[i*4 +: 4]), m_cnt[i]);
    chk(tag, "rsp", int'({rsp_grant, rsp_busy, rsp_cap_err}), int'({e_grant, e_busy, e_cap}));
    if (e_grant) chk(tag, "index", int'(rsp_index), e_idx);
  endtask

  task automatic model_reset();
    m_busy = '0; m_run = '0; m_err = '0; m_pool = 10;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    e_grant = 0; e_busy = 0; e_cap = 0; e_idx = 0;
  endtask

  task automatic op(input string tag, input bit rv, input int rc, input bit lv, input int li,
                    input logic [2:0] st, input logic [2:0] sp, input logic [2:0] es);
    logic [2:0] old_busy;
    int order [3];
    int pick;
    @(negedge clk);
    req_valid = rv; req_count = 4'(rc); rel_valid = lv; rel_index = 2'(li);
    run_start = st; run_stop = sp; err_set = es;
    old_busy = m_busy;
    m_run = (m_run | (st & old_busy)) & ~sp;
    m_err = m_err | (es & old_busy);
    if (lv && li < 3 && m_busy[li]) begin
      m_pool += m_cnt[li]; m_cnt[li] = 0;
      m_busy[li] = 1'b0; m_run[li] = 1'b0; m_err[li] = 1'b0;
    end
    e_grant = 0; e_busy = 0; e_cap = 0; e_idx = 0;
    if (rv) begin
      order[0] = 0; order[1] = 2; order[2] = 1;
      pick = -1;
      for (int k = 2; k >= 0; k--) if (!m_busy[order[k]]) pick = order[k];
      if (pick < 0) e_busy = 1;
      else if (rc < 1 || rc > 10 || rc > m_pool) e_cap = 1;
      else begin
        e_grant = 1; e_idx = pick;
        m_busy[pick] = 1'b1; m_cnt[pick] = rc; m_pool -= rc;
      end
    end
    @(posedge clk);
    #1;
    compare_all(tag);
    req_valid = 0; rel_valid = 0; run_start = '0; run_stop = '0; err_set = '0;
  endtask

  task automatic release_all();
    for (int i = 0; i < 3; i++) op("R6", 0, 0, 1, i, 3'b000, 3'b000, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R7 and R5: every count from a fresh state
    for (int c = 0; c < 16; c++) begin
      op("R7", 1, c, 0, 0, 3'b000, 3'b000, 3'b000);
      release_all();
    end

    // R4 and R5: two requests across the whole valid range
    for (int a = 1; a <= 10; a++)
      for (int b = 1; b <= 10; b++) begin
        op("R5", 1, a, 0, 0, 3'b000, 3'b000, 3'b000);
        op("R4", 1, b, 0, 0, 3'b000, 3'b000, 3'b000);
        release_all();
      end

    // R2 order, R3 busy and priority
    op("R2", 1, 2, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R2", 1, 3, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R2", 1, 4, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R3", 1, 1, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R3", 1, 15, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R3", 1, 0, 0, 0, 3'b000, 3'b000, 3'b000);

    // R6 release C then R4 over budget, then refill
    op("R6", 0, 0, 1, 2, 3'b000, 3'b000, 3'b000);
    op("R4", 1, 5, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R2", 1, 4, 0, 0, 3'b000, 3'b000, 3'b000);

    // R8 and R11 on occupied and free contexts
    op("R8", 0, 0, 0, 0, 3'b111, 3'b000, 3'b000);
    op("R11", 0, 0, 0, 0, 3'b000, 3'b000, 3'b101);
    op("R8", 0, 0, 0, 0, 3'b000, 3'b010, 3'b000);
    op("R11", 0, 0, 1, 0, 3'b000, 3'b000, 3'b000);
    op("R8", 0, 0, 0, 0, 3'b001, 3'b000, 3'b001);
    op("R11", 0, 0, 0, 0, 3'b000, 3'b000, 3'b000);

    // R9 release and request together
    op("R9", 1, 3, 1, 2, 3'b000, 3'b000, 3'b000);
    op("R9", 1, 7, 1, 1, 3'b000, 3'b000, 3'b000);

    // R10 releases of free or nonexistent contexts
    op("R10", 0, 0, 1, 3, 3'b000, 3'b000, 3'b000);
    op("R10", 0, 0, 1, 0, 3'b000, 3'b000, 3'b000);
    op("R10", 0, 0, 1, 0, 3'b000, 3'b000, 3'b000);
    release_all();
    op("R10", 0, 0, 1, 1, 3'b000, 3'b000, 3'b000);
    op("R9", 1, 10, 0, 0, 3'b000, 3'b000, 3'b000);
    op("R9", 1, 10, 1, 0, 3'b001, 3'b000, 3'b001);
    op("R1", 0, 0, 0, 0, 3'b000, 3'b000, 3'b000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule